// File: doc/BRIEF.md
# Multi-master I2C byte engine

This block drives the two open-drain lines of an I2C bus on behalf of a local controller that issues byte-level commands. It leaves reset as a passive slave-role agent and touches neither line. A start command, accepted only when the bus is free, forms a START condition and makes the block the bus master. Each byte command then clocks out eight bits, most significant first, plus a ninth acknowledge clock. Writes sample the far end's acknowledge. Reads collect eight bits and answer with a chosen acknowledge level. A stop command forms a STOP condition and hands the role back.

Several masters may share the bus. A monitor follows START and STOP conditions on the lines to keep a bus-busy flag. While transmitting, the engine compares every bit it leaves high against what the bus really shows. On a mismatch it frees both lines in the same clock edge and falls back to slave role. SCL timing comes from a divider whose phase length is a standard-rate or fast-rate count, selected by a mode input.

Top module: `i2c_mm_master`

## Requirements
- R1: After reset is_master, scl_oe, sda_oe, arb_lost, byte_done and start_done are 0, and bus_busy is 0 while both lines are high.
- R2: A start_req taken while idle and bus_busy is 0 sets is_master one cycle later. It then drives SDA low with SCL released, and after that SCL low. start_done rises when this START sequence ends.
- R3: A stop_req while master and holding the bus drives SDA low with SCL low, then releases SCL, then releases SDA. is_master clears when the SDA release phase ends, leaving both lines released.
- R4: A byte_req while master and holding the bus sends 8 bits MSB first plus a ninth clock. When byte_rd is 0 it transmits tx_data and latches the bus level of the ninth bit into ack_rcvd (0 means acknowledged). When byte_rd is 1 it releases SDA for 8 bits, loads them into rx_data and drives ack_send on the ninth bit. byte_done rises at the end of the ninth SCL high phase.
- R5: Every SCL high phase and every SCL low phase inside a byte lasts div_fast clock cycles when fast_mode is 1 and div_std cycles when it is 0. Both counts must be at least 4.
- R6: While SCL is released, sda_oe changes only to form a START (SDA falls) or a STOP (SDA rises).
- R7: If a transmitted data bit is left high but SDA reads low at the end of its SCL high phase, then in the same edge scl_oe and sda_oe drop to 0, arb_lost sets and is_master clears. byte_done stays 0.
- R8: bus_busy sets after any START on the lines (SDA falling while SCL is high) and clears after any STOP (SDA rising while SCL is high). It follows the lines through a SYNC_STAGES-deep synchronizer.
- R9: A start_req while bus_busy is 1 and not master is refused. A byte_req or stop_req while not master is ignored. In both cases the lines stay released and is_master stays 0.
- R10: A start_req while master and holding the bus forms a repeated START: SCL low with SDA released, then both released, then a normal START. is_master stays 1 throughout.
- R11: xmit is 1 while master and the latest byte command was a write. It is 0 after a read command and whenever not master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_mode | input | 1 | 1 selects div_fast phase length, 0 selects div_std |
| div_std | input | DIV_W | Standard-rate SCL phase length in cycles (>= 4) |
| div_fast | input | DIV_W | Fast-rate SCL phase length in cycles (>= 4) |
| start_req | input | 1 | One-cycle START / repeated START command |
| stop_req | input | 1 | One-cycle STOP command |
| byte_req | input | 1 | One-cycle byte transfer command |
| byte_rd | input | 1 | Direction of the byte command: 1 read, 0 write |
| tx_data | input | 8 | Byte to transmit |
| ack_send | input | 1 | Acknowledge level sent after a read byte (0 = ACK) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_data | output | 8 | Last byte seen on the bus |
| ack_rcvd | output | 1 | Ninth-bit level of the last byte |
| is_master | output | 1 | Master role |
| bus_busy | output | 1 | Bus held by some master |
| arb_lost | output | 1 | Arbitration lost, cleared by the next accepted START |
| byte_done | output | 1 | Byte finished, cleared by the next accepted command |
| start_done | output | 1 | START finished, cleared by the next accepted command |
| xmit | output | 1 | Master and transmitting |

## Verification
Commands take effect at the first clock edge. The role flag and both line drives are checked at the falling clock edge that follows, one cycle after the request. Byte, START and STOP completion come only after a number of divider phases, so the bench polls the completion flags. It then waits one more cycle, so that its bus monitor has recorded the last SCL edge, before it compares the captured bits, the measured high-phase length and the returned data against values worked out in its own functions. bus_busy trails the lines by the synchronizer plus one edge detection stage, and the bench allows a few cycles for it.

// File: rtl/i2cm_pkg.sv
// Shared types for the multi-master I2C byte engine.
// Assumes an 8-bit byte followed by one acknowledge bit.
package i2cm_pkg;
    localparam int BYTE_W  = 8;
    localparam int ACK_IDX = BYTE_W;          // bit index of the ninth clock
    localparam int BIDX_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,    // slave role, lines released
        ST_RS_A,    // repeated start: SCL low, SDA released
        ST_RS_B,    // repeated start: both released
        ST_STA_A,   // START: SDA low, SCL released
        ST_STA_B,   // START: both low
        ST_HOLD,    // master, SCL held low, waiting for a command
        ST_BIT_LO,  // bit cell, SCL low
        ST_BIT_HI,  // bit cell, SCL released
        ST_STO_A,   // STOP: both low
        ST_STO_B,   // STOP: SCL released, SDA low
        ST_STO_C    // STOP: both released
    } eng_state_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;
endpackage

// File: rtl/i2cm_clkdiv.sv
// Phase timer: gives a one-cycle tick every 'period' cycles and restarts
// whenever the engine changes phase. Assumes period >= 2.
module i2cm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_mode,
    input  logic [DIV_W-1:0] div_std,
    input  logic [DIV_W-1:0] div_fast,
    input  logic             load,
    output logic             tick
);
    logic [DIV_W-1:0] period;
    logic [DIV_W-1:0] cnt;

    // Pick the phase length for the selected bus rate.
    always_comb period = fast_mode ? div_fast : div_std;

    // Down-counter: reload on a phase change or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= period - 1'b1;
        else if (cnt == '0)      cnt <= period - 1'b1;
        else                     cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);
endmodule

// File: rtl/i2cm_busmon.sv
// Line monitor: synchronizes SCL/SDA and tracks START/STOP to keep the
// bus-busy flag. Assumes SYNC_STAGES >= 1.
module i2cm_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic busy
);
    logic scl_s, scl_d, sda_d;
    logic start_seen, stop_seen;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin scl_s <= 1'b1; sda_s <= 1'b1; end
                else        begin scl_s <= scl_i; sda_s <= sda_i; end
            end
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] scl_q, sda_q;
            // Shift chain, oldest sample at the top.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
                    sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
                end
            end
            assign scl_s = scl_q[SYNC_STAGES-1];
            assign sda_s = sda_q[SYNC_STAGES-1];
        end
    endgenerate

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin scl_d <= 1'b1; sda_d <= 1'b1; end
        else        begin scl_d <= scl_s; sda_d <= sda_s; end
    end

    assign start_seen = scl_s && scl_d && sda_d && !sda_s;
    assign stop_seen  = scl_s && scl_d && !sda_d && sda_s;

    // Busy from any START until the next STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy <= 1'b0;
        else if (start_seen) busy <= 1'b1;
        else if (stop_seen)  busy <= 1'b0;
    end
endmodule

// File: rtl/i2cm_engine.sv
// Master sequencer: START, repeated START, byte cells with the ninth clock,
// STOP and arbitration. Advances one phase per divider tick. Assumes the
// sampled SDA lags the pins by less than one phase.
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              byte_req,
    input  logic              byte_rd,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              ack_send,
    input  logic              busy,
    input  logic              sda_s,
    output logic              load,
    output eng_state_t        st_o,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              ack_rcvd,
    output logic              is_master,
    output logic              arb_lost,
    output logic              byte_done,
    output logic              start_done,
    output logic              xmit
);
    eng_state_t        st, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [BIDX_W-1:0] bidx;
    logic              rd, ack_l;
    logic              acc_start, acc_stop, acc_byte;
    logic              bitval, own_bit, lost, last_bit;
    line_drive_t       drv;

    // Command acceptance, priority START over STOP over byte.
    always_comb begin
        acc_start = start_req && ((st == ST_IDLE && !busy) || st == ST_HOLD);
        acc_stop  = stop_req && !start_req && st == ST_HOLD;
        acc_byte  = byte_req && !start_req && !stop_req && st == ST_HOLD;
    end

    // Level of the current bit cell and whether arbitration applies.
    always_comb begin
        last_bit = (bidx == BIDX_W'(ACK_IDX));
        if (last_bit) bitval = rd ? ack_l : 1'b1;
        else          bitval = rd ? 1'b1 : shreg[BYTE_W-1];
        own_bit = !rd && !last_bit;
        lost    = (st == ST_BIT_HI) && tick && own_bit && bitval && !sda_s;
    end

    // Next phase.
    always_comb begin
        nxt = st;
        case (st)
            ST_IDLE:   if (acc_start) nxt = ST_STA_A;
            ST_HOLD: begin
                if (acc_start)      nxt = ST_RS_A;
                else if (acc_stop)  nxt = ST_STO_A;
                else if (acc_byte)  nxt = ST_BIT_LO;
            end
            ST_RS_A:   if (tick) nxt = ST_RS_B;
            ST_RS_B:   if (tick) nxt = ST_STA_A;
            ST_STA_A:  if (tick) nxt = ST_STA_B;
            ST_STA_B:  if (tick) nxt = ST_HOLD;
            ST_BIT_LO: if (tick) nxt = ST_BIT_HI;
            ST_BIT_HI: if (tick) nxt = lost ? ST_IDLE : (last_bit ? ST_HOLD : ST_BIT_LO);
            ST_STO_A:  if (tick) nxt = ST_STO_B;
            ST_STO_B:  if (tick) nxt = ST_STO_C;
            ST_STO_C:  if (tick) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign load = (nxt != st);

    // Line drive per phase.
    always_comb begin
        case (st)
            ST_RS_A, ST_HOLD:    drv = '{scl_low: 1'b1, sda_low: 1'b0};
            ST_STA_A, ST_STO_B:  drv = '{scl_low: 1'b0, sda_low: 1'b1};
            ST_STA_B, ST_STO_A:  drv = '{scl_low: 1'b1, sda_low: 1'b1};
            ST_BIT_LO:           drv = '{scl_low: 1'b1, sda_low: !bitval};
            ST_BIT_HI:           drv = '{scl_low: 1'b0, sda_low: !bitval};
            default:             drv = '{scl_low: 1'b0, sda_low: 1'b0};
        endcase
    end

    assign scl_oe = drv.scl_low;
    assign sda_oe = drv.sda_low;
    assign st_o   = st;
    assign xmit   = is_master && !rd;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Role, flags, shifter and received data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_master  <= 1'b0;
            arb_lost   <= 1'b0;
            byte_done  <= 1'b0;
            start_done <= 1'b0;
            shreg      <= '0;
            bidx       <= '0;
            rd         <= 1'b0;
            ack_l      <= 1'b1;
            rx_data    <= '0;
            ack_rcvd   <= 1'b1;
        end else begin
            if (acc_start) begin
                is_master  <= 1'b1;
                arb_lost   <= 1'b0;
                byte_done  <= 1'b0;
                start_done <= 1'b0;
            end
            if (acc_stop) begin
                byte_done  <= 1'b0;
                start_done <= 1'b0;
            end
            if (acc_byte) begin
                shreg      <= tx_data;
                rd         <= byte_rd;
                ack_l      <= ack_send;
                bidx       <= '0;
                byte_done  <= 1'b0;
                start_done <= 1'b0;
            end
            if (st == ST_STA_B && tick) start_done <= 1'b1;
            if (st == ST_BIT_HI && tick) begin
                if (lost) begin
                    arb_lost  <= 1'b1;
                    is_master <= 1'b0;
                end else begin
                    shreg <= {shreg[BYTE_W-2:0], sda_s};
                    if (last_bit) begin
                        rx_data   <= shreg;
                        ack_rcvd  <= sda_s;
                        byte_done <= 1'b1;
                    end else begin
                        bidx <= bidx + 1'b1;
                    end
                end
            end
            if (st == ST_STO_C && tick) is_master <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_mm_master.sv
// Top of the multi-master I2C byte engine: phase timer, line monitor and
// sequencer. Lines are open drain: an *_oe of 1 pulls the line low.
module i2c_mm_master #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_mode,
    input  logic [DIV_W-1:0] div_std,
    input  logic [DIV_W-1:0] div_fast,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             byte_req,
    input  logic             byte_rd,
    input  logic [7:0]       tx_data,
    input  logic             ack_send,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic [7:0]       rx_data,
    output logic             ack_rcvd,
    output logic             is_master,
    output logic             bus_busy,
    output logic             arb_lost,
    output logic             byte_done,
    output logic             start_done,
    output logic             xmit
);
    import i2cm_pkg::*;

    logic       tick, load, sda_s;
    eng_state_t eng_st;

    i2cm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode),
        .div_std(div_std), .div_fast(div_fast), .load(load), .tick(tick)
    );

    i2cm_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .busy(bus_busy)
    );

    i2cm_engine u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start_req(start_req), .stop_req(stop_req), .byte_req(byte_req),
        .byte_rd(byte_rd), .tx_data(tx_data), .ack_send(ack_send),
        .busy(bus_busy), .sda_s(sda_s), .load(load), .st_o(eng_st),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data),
        .ack_rcvd(ack_rcvd), .is_master(is_master), .arb_lost(arb_lost),
        .byte_done(byte_done), .start_done(start_done), .xmit(xmit)
    );
endmodule

// File: rtl/i2cm_checker.sv
// Property checker for the I2C byte engine, bound to the top module.
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       bus_busy,
    input logic       is_master,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       arb_lost,
    input eng_state_t st
);
    AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!is_master && !scl_oe && !sda_oe && !arb_lost)); // R1

    AST_START_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && st == ST_IDLE && !bus_busy) |=> is_master); // R2

    AST_STOP_DROPS_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_STO_C && st == ST_IDLE) |-> (!is_master && !scl_oe && !sda_oe)); // R3

    AST_SDA_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && !$stable(sda_oe)) |-> (st == ST_STA_A || st == ST_STO_C)); // R6

    AST_LOSS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> (!scl_oe && !sda_oe && !is_master)); // R7

    AST_BUSY_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && bus_busy && !is_master) |=> !is_master); // R9
endmodule

bind i2c_mm_master i2cm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .bus_busy(bus_busy),
    .is_master(is_master), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .arb_lost(arb_lost), .st(eng_st)
);

// File: tb/i2c_mm_master_bench.sv
// Self-checking bench: wired-AND bus with a slave model and a competing agent.
module i2c_mm_master_bench;
    localparam int DSTD = 12;
    localparam int DFST = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0, fast_mode = 1'b0;
    logic       start_req = 1'b0, stop_req = 1'b0, byte_req = 1'b0, byte_rd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       ack_send = 1'b0;
    logic       scl_oe, sda_oe, ack_rcvd, is_master, bus_busy, arb_lost;
    logic       byte_done, start_done, xmit;
    logic [7:0] rx_data;

    logic       oth_sda = 1'b0, slv_act = 1'b0, slv_rd = 1'b0, slv_ack = 1'b0;
    logic [7:0] slv_byte = 8'h00;
    int         falls = 0, base = 0, hi_len = 0, hi_cur = 0, n_sta = 0, n_sto = 0;
    logic [8:0] mon_bits = '0;
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    int         total = 0, bad = 0;
    logic       finished = 1'b0;

    int  scnt;
    logic scl_bus, sda_bus, slv_low;
    assign scnt    = falls - base;
    assign slv_low = slv_act && ((slv_rd && scnt < 8 && !slv_byte[3'(7 - scnt)]) ||
                                 (!slv_rd && scnt == 8 && !slv_ack));
    assign scl_bus = !scl_oe;
    assign sda_bus = !sda_oe && !oth_sda && !slv_low;

    i2c_mm_master u_i2c_mm_master (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode),
        .div_std(8'(DSTD)), .div_fast(8'(DFST)),
        .start_req(start_req), .stop_req(stop_req), .byte_req(byte_req),
        .byte_rd(byte_rd), .tx_data(tx_data), .ack_send(ack_send),
        .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rx_data(rx_data), .ack_rcvd(ack_rcvd), .is_master(is_master),
        .bus_busy(bus_busy), .arb_lost(arb_lost), .byte_done(byte_done),
        .start_done(start_done), .xmit(xmit)
    );

    // Bus monitor: bits on SCL rise, high-phase length, START/STOP counts.
    always @(negedge clk) begin
        if (scl_bus && !prev_scl) begin
            mon_bits = {mon_bits[7:0], sda_bus};
            hi_cur   = 1;
        end else if (scl_bus) hi_cur = hi_cur + 1;
        if (!scl_bus && prev_scl) begin
            hi_len = hi_cur;
            falls  = falls + 1;
        end
        if (scl_bus && prev_scl && prev_sda && !sda_bus) n_sta = n_sta + 1;
        if (scl_bus && prev_scl && !prev_sda && sda_bus) n_sto = n_sto + 1;
        prev_scl = scl_bus;
        prev_sda = sda_bus;
    end

    function automatic int phase_len(input logic fm);
        return fm ? DFST : DSTD;
    endfunction

    function automatic logic [8:0] wr_frame(input logic [7:0] d, input logic a);
        return {d, a};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_start(input logic repeated);
        int sta0 = n_sta;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        chk("R2 master next cycle", is_master, 1);
        for (int i = 0; i < 4000 && !start_done; i++) @(negedge clk);
        chk(repeated ? "R10 repeated start done" : "R2 start done", start_done, 1);
        chk("R2 START on bus", n_sta - sta0, 1);
        wait_cyc(4);
        chk("R8 busy after start", bus_busy, 1);
        if (repeated) chk("R10 still master", is_master, 1);
    endtask

    task automatic do_byte(input logic rd, input logic [7:0] d, input logic am,
                           input logic sack, input logic [7:0] sbyte);
        @(negedge clk);
        slv_act = 1'b1; slv_rd = rd; slv_ack = sack; slv_byte = sbyte;
        base = falls; byte_rd = rd; tx_data = d; ack_send = am; byte_req = 1'b1;
        @(negedge clk) byte_req = 1'b0;
        for (int i = 0; i < 8000 && !byte_done; i++) @(negedge clk);
        @(negedge clk);
        slv_act = 1'b0;
        chk("R4 byte done", byte_done, 1);
        chk("R5 SCL high length", hi_len, phase_len(fast_mode));
        if (!rd) begin
            chk("R4 write bits MSB first", int'(mon_bits), int'(wr_frame(d, sack)));
            chk("R4 ack sampled", ack_rcvd, sack);
            chk("R11 xmit on write", xmit, 1);
        end else begin
            chk("R4 read data", rx_data, sbyte);
            chk("R4 master ack bit", mon_bits[0], am);
            chk("R11 xmit on read", xmit, 0);
        end
    endtask

    task automatic do_stop();
        int sto0 = n_sto;
        @(negedge clk) stop_req = 1'b1;
        @(negedge clk) stop_req = 1'b0;
        for (int i = 0; i < 4000 && is_master; i++) @(negedge clk);
        chk("R3 role dropped", is_master, 0);
        chk("R3 lines released", {scl_oe, sda_oe}, 0);
        wait_cyc(5);
        chk("R3 STOP on bus", n_sto - sto0, 1);
        chk("R8 busy cleared", bus_busy, 0);
        chk("R11 xmit idle", xmit, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        wait_cyc(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 master", is_master, 0);
        chk("R1 lines", {scl_oe, sda_oe}, 0);
        chk("R1 flags", {arb_lost, byte_done, start_done}, 0);
        chk("R1 busy", bus_busy, 0);

        // R9 commands ignored while not master
        @(negedge clk) byte_req = 1'b1; stop_req = 1'b1;
        @(negedge clk) byte_req = 1'b0; stop_req = 1'b0;
        wait_cyc(30);
        chk("R9 ignored byte/stop lines", {scl_oe, sda_oe}, 0);
        chk("R9 ignored byte/stop role", {is_master, byte_done}, 0);

        // Directed standard-rate transaction
        do_start(1'b0);
        do_byte(1'b0, 8'hA4, 1'b0, 1'b0, 8'h00);
        do_byte(1'b1, 8'h00, 1'b0, 1'b0, 8'h5B);
        do_start(1'b1);
        do_byte(1'b0, 8'hFF, 1'b0, 1'b1, 8'h00);
        do_byte(1'b1, 8'h00, 1'b1, 1'b0, 8'h81);
        do_stop();

        // Random transactions at fast rate
        fast_mode = 1'b1;
        for (int t = 0; t < 6; t++) begin
            int nb = 1 + int'($urandom_range(3));
            do_start(1'b0);
            for (int b = 0; b < nb; b++)
                do_byte(1'($urandom_range(1)), 8'($urandom), 1'($urandom_range(1)),
                        1'($urandom_range(1)), 8'($urandom));
            do_stop();
        end

        // R8/R9 another master holds the bus
        @(negedge clk) oth_sda = 1'b1;
        wait_cyc(6);
        chk("R8 busy from foreign START", bus_busy, 1);
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        chk("R9 start refused", is_master, 0);
        wait_cyc(30);
        chk("R9 lines stay released", {scl_oe, sda_oe}, 0);
        @(negedge clk) oth_sda = 1'b0;
        wait_cyc(6);
        chk("R8 busy from foreign STOP", bus_busy, 0);

        // R7 arbitration loss on the first high data bit of 0x0F
        fast_mode = 1'b0;
        do_start(1'b0);
        @(negedge clk) oth_sda = 1'b1;
        byte_rd = 1'b0; tx_data = 8'h0F; byte_req = 1'b1;
        @(negedge clk) byte_req = 1'b0;
        for (int i = 0; i < 4000 && !arb_lost; i++) @(negedge clk);
        chk("R7 arb lost flag", arb_lost, 1);
        chk("R7 lines released", {scl_oe, sda_oe}, 0);
        chk("R7 role dropped", is_master, 0);
        chk("R7 no byte done", byte_done, 0);
        chk("R7 four zero bits sent", falls - base >= 4, 1);
        @(negedge clk) oth_sda = 1'b0;
        wait_cyc(6);
        chk("R8 bus free after loss", bus_busy, 0);
        do_start(1'b0);
        chk("R7 flag cleared by start", arb_lost, 0);
        do_stop();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule